// File: doc/BRIEF.md
# Direct-Mapped Page Translation Cache

This block keeps recently used virtual-to-physical page translations in a small table with one possible slot per page. A client presents a virtual page number on a valid/ready request port. If the chosen slot already holds that page, the block answers on the next cycle with the stored physical page number and the permission flags. If the slot does not hold it, the block sends the page number out on a page-table lookup port and waits for the reply. It then overwrites the slot and answers with the fetched physical page number.

The slot is chosen by the most significant bits of the virtual page number. Pages that share those bits compete for one slot, and each refill pushes the other page out. A refill runs as three ordered steps. First the slot's valid flag is cleared. Then the tag and the translation are written. Last, the slot is marked valid, readable and writable. A flush input clears every valid flag at once. Only one request is handled at a time.

Top module: `dmtlb`

## Requirements
- R1: The slot for a request is bits [VPN_W-1 : VPN_W-IDX_W] of the virtual page number (bits 19:16 with the default sizes). Pages that differ in these bits use different slots and can be held at the same time.
- R2: A lookup hits only when the chosen slot is valid and its stored tag equals the whole requested page number. On a hit, the cycle after acceptance has rsp_valid=1, rsp_hit=1, rsp_ppn equal to the stored physical page, and rsp_rd=rsp_wr=1.
- R3: On a miss, pt_req_valid rises the cycle after acceptance with pt_req_vpn equal to the requested page. Both hold steady until pt_req_ready is seen high. No response is given before the reply arrives.
- R4: The cycle after pt_rsp_valid is sampled high, the block gives rsp_valid=1, rsp_hit=0, rsp_ppn equal to the reply's physical page, and rsp_rd=rsp_wr=1.
- R5: A refill clears the slot's valid flag on the reply edge. It writes the tag and the physical page on the next edge, and sets valid, read and write on the edge after that. req_ready stays 0 until the refill has finished.
- R6: Two pages with the same index bits evict each other. After one of them is refilled, a lookup of the other misses.
- R7: flush_all clears every valid flag. A request accepted in the same cycle as flush_all is a miss.
- R8: A flush_all that arrives while a refill is in progress clears every other entry. The refilled entry still ends valid and hits afterwards.
- R9: Synchronous reset clears every valid flag and leaves req_ready=1, rsp_valid=0 and pt_req_valid=0.
- R10: Only one request is outstanding at a time. req_ready is 0 from acceptance until the request is finished, and rsp_valid lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush_all | input | 1 | Clears all valid flags |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 = answered from the table, 0 = refilled |
| rsp_ppn | output | PPN_W | Physical page number |
| rsp_rd | output | 1 | Read permission |
| rsp_wr | output | 1 | Write permission |
| pt_req_valid | output | 1 | Page-table lookup request |
| pt_req_ready | input | 1 | Page-table side takes the request |
| pt_req_vpn | output | VPN_W | Page to look up |
| pt_rsp_valid | input | 1 | Page-table reply present |
| pt_rsp_ppn | input | PPN_W | Reply physical page number |

## Verification
A flush can fall in the same cycle as a table operation: an accepted lookup, or one step of a refill. The bench drives flush_all together with a request and expects a miss. It also drives flush_all during the wait for the reply and on the edge that writes the tag. In each case a reference model clears its table first and installs the refilled page afterwards. The bench then checks that entries filled earlier miss while the refilled page hits.

// File: rtl/dmtlb_pkg.sv
package dmtlb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIT_RSP,
    ST_PT_REQ,
    ST_PT_WAIT,
    ST_FILL_WR,
    ST_FILL_CTL
  } tlb_state_e;

endpackage

// File: rtl/dmtlb_store.sv
module dmtlb_store #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  parameter int SLOTS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_vld,
  output logic [VPN_W-1:0] lk_tag,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_rd,
  output logic             lk_wr,
  input  logic             inv_i,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             ctl_i,
  input  logic [IDX_W-1:0] ctl_idx
);

  logic [SLOTS-1:0] vld_vec;
  logic [SLOTS-1:0] rd_vec;
  logic [SLOTS-1:0] wr_vec;
  logic [VPN_W-1:0] tag_arr [SLOTS];
  logic [PPN_W-1:0] ppn_arr [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic             vld_r, rd_r, wr_r;
    logic [VPN_W-1:0] tag_r;
    logic [PPN_W-1:0] ppn_r;
    wire sel_inv = inv_i && (inv_idx == IDX_W'(s));
    wire sel_wr  = wr_i  && (wr_idx  == IDX_W'(s));
    wire sel_ctl = ctl_i && (ctl_idx == IDX_W'(s));

    // Control step of a refill wins over flush and single invalidate.
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_r <= 1'b0;
        rd_r  <= 1'b0;
        wr_r  <= 1'b0;
      end else if (sel_ctl) begin
        vld_r <= 1'b1;
        rd_r  <= 1'b1;
        wr_r  <= 1'b1;
      end else if (flush_i || sel_inv) begin
        vld_r <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tag_r <= '0;
        ppn_r <= '0;
      end else if (sel_wr) begin
        tag_r <= wr_tag;
        ppn_r <= wr_ppn;
      end
    end

    assign vld_vec[s] = vld_r;
    assign rd_vec[s]  = rd_r;
    assign wr_vec[s]  = wr_r;
    assign tag_arr[s] = tag_r;
    assign ppn_arr[s] = ppn_r;
  end

  assign lk_vld = vld_vec[lk_idx];
  assign lk_rd  = rd_vec[lk_idx];
  assign lk_wr  = wr_vec[lk_idx];
  assign lk_tag = tag_arr[lk_idx];
  assign lk_ppn = ppn_arr[lk_idx];

  // R7: a flush with no control step leaves no valid entry
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
    (flush_i && !ctl_i) |=> (vld_vec == '0));

  // R8: a flush together with the control step leaves only the refilled slot
  a_r8_fill_survives: assert property (@(posedge clk) disable iff (rst)
    (flush_i && ctl_i) |=> (vld_vec == (SLOTS'(1) << $past(ctl_idx))));

  // R5: the first refill step drops the slot's valid flag
  a_r5_inv_drops: assert property (@(posedge clk) disable iff (rst)
    (inv_i && !ctl_i) |=> !vld_vec[$past(inv_idx)]);

  // R5: the control step leaves the slot valid, readable and writable
  a_r5_ctl_sets: assert property (@(posedge clk) disable iff (rst)
    ctl_i |=> (vld_vec[$past(ctl_idx)] && rd_vec[$past(ctl_idx)] && wr_vec[$past(ctl_idx)]));

endmodule

// File: rtl/dmtlb_ctrl.sv
module dmtlb_ctrl
  import dmtlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             pt_req_valid,
  input  logic             pt_req_ready,
  output logic [VPN_W-1:0] pt_req_vpn,
  input  logic             pt_rsp_valid,
  input  logic [PPN_W-1:0] pt_rsp_ppn,
  output logic [IDX_W-1:0] lk_idx,
  input  logic             lk_vld,
  input  logic [VPN_W-1:0] lk_tag,
  input  logic [PPN_W-1:0] lk_ppn,
  input  logic             lk_rd,
  input  logic             lk_wr,
  output logic             inv_ev,
  output logic             wr_ev,
  output logic             ctl_ev,
  output logic [IDX_W-1:0] fill_idx,
  output logic [VPN_W-1:0] fill_tag,
  output logic [PPN_W-1:0] fill_ppn
);

  // Slot selection: upper bits of the page number.
  function automatic logic [IDX_W-1:0] slot_of(input logic [VPN_W-1:0] v);
    return v[VPN_W-1 -: IDX_W];
  endfunction

  // Hit test: valid, full tag equal, and not being flushed this cycle.
  function automatic logic is_hit(input logic vld, input logic [VPN_W-1:0] tag,
                                  input logic [VPN_W-1:0] v, input logic fl);
    return vld && !fl && (tag == v);
  endfunction

  tlb_state_e       state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic [IDX_W-1:0] idx_q;
  logic [PPN_W-1:0] ppn_q;
  logic             rd_q, wr_q;

  wire accept  = req_valid && req_ready;
  wire hit_now = is_hit(lk_vld, lk_tag, req_vpn, flush_i);
  wire pt_take = pt_req_valid && pt_req_ready;

  assign lk_idx       = slot_of(req_vpn);
  assign req_ready    = (state_q == ST_IDLE);
  assign pt_req_valid = (state_q == ST_PT_REQ);
  assign pt_req_vpn   = vpn_q;
  assign rsp_valid    = (state_q == ST_HIT_RSP) || (state_q == ST_FILL_WR);
  assign rsp_hit      = (state_q == ST_HIT_RSP);
  assign rsp_ppn      = ppn_q;
  assign rsp_rd       = rd_q;
  assign rsp_wr       = wr_q;

  assign inv_ev   = (state_q == ST_PT_WAIT) && pt_rsp_valid;
  assign wr_ev    = (state_q == ST_FILL_WR);
  assign ctl_ev   = (state_q == ST_FILL_CTL);
  assign fill_idx = idx_q;
  assign fill_tag = vpn_q;
  assign fill_ppn = ppn_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept) state_d = hit_now ? ST_HIT_RSP : ST_PT_REQ;
      ST_HIT_RSP:  state_d = ST_IDLE;
      ST_PT_REQ:   if (pt_take) state_d = ST_PT_WAIT;
      ST_PT_WAIT:  if (pt_rsp_valid) state_d = ST_FILL_WR;
      ST_FILL_WR:  state_d = ST_FILL_CTL;
      ST_FILL_CTL: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      idx_q   <= '0;
      ppn_q   <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vpn_q <= req_vpn;
        idx_q <= lk_idx;
        if (hit_now) begin
          ppn_q <= lk_ppn;
          rd_q  <= lk_rd;
          wr_q  <= lk_wr;
        end
      end
      if (inv_ev) begin
        ppn_q <= pt_rsp_ppn;
        rd_q  <= 1'b1;
        wr_q  <= 1'b1;
      end
    end
  end

  // R2: a hit answers on the next cycle with the stored translation
  a_r2_hit_answer: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_now) |=> (rsp_valid && rsp_hit && rsp_ppn == $past(lk_ppn)));

  // R3: a miss issues the page-table request on the next cycle
  a_r3_miss_issue: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit_now) |=> (pt_req_valid && !rsp_valid && pt_req_vpn == $past(req_vpn)));

  // R3: the page-table request holds until taken
  a_r3_pt_hold: assert property (@(posedge clk) disable iff (rst)
    (pt_req_valid && !pt_req_ready) |=> (pt_req_valid && $stable(pt_req_vpn)));

  // R4: a reply produces the refill answer on the next cycle
  a_r4_fill_answer: assert property (@(posedge clk) disable iff (rst)
    inv_ev |=> (rsp_valid && !rsp_hit && rsp_ppn == $past(pt_rsp_ppn) && rsp_rd && rsp_wr));

  // R5: refill steps in order: invalidate, write, control
  a_r5_write_after_inv: assert property (@(posedge clk) disable iff (rst)
    wr_ev |-> $past(inv_ev));
  a_r5_ctl_after_write: assert property (@(posedge clk) disable iff (rst)
    ctl_ev |-> $past(wr_ev));

  // R10: single outstanding request, one-cycle response strobe
  a_r10_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    (pt_req_valid || rsp_valid || ctl_ev) |-> !req_ready);
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/dmtlb.sv
module dmtlb #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  parameter int SLOTS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_all,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             pt_req_valid,
  input  logic             pt_req_ready,
  output logic [VPN_W-1:0] pt_req_vpn,
  input  logic             pt_rsp_valid,
  input  logic [PPN_W-1:0] pt_rsp_ppn
);

  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic             lk_vld, lk_rd, lk_wr;
  logic [VPN_W-1:0] lk_tag, fill_tag;
  logic [PPN_W-1:0] lk_ppn, fill_ppn;
  logic             inv_ev, wr_ev, ctl_ev;

  dmtlb_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .flush_i(flush_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .pt_req_valid(pt_req_valid), .pt_req_ready(pt_req_ready), .pt_req_vpn(pt_req_vpn),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_ppn(pt_rsp_ppn),
    .lk_idx(lk_idx), .lk_vld(lk_vld), .lk_tag(lk_tag), .lk_ppn(lk_ppn),
    .lk_rd(lk_rd), .lk_wr(lk_wr),
    .inv_ev(inv_ev), .wr_ev(wr_ev), .ctl_ev(ctl_ev),
    .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_ppn(fill_ppn)
  );

  dmtlb_store #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .flush_i(flush_all),
    .lk_idx(lk_idx), .lk_vld(lk_vld), .lk_tag(lk_tag), .lk_ppn(lk_ppn),
    .lk_rd(lk_rd), .lk_wr(lk_wr),
    .inv_i(inv_ev), .inv_idx(fill_idx),
    .wr_i(wr_ev), .wr_idx(fill_idx), .wr_tag(fill_tag), .wr_ppn(fill_ppn),
    .ctl_i(ctl_ev), .ctl_idx(fill_idx)
  );

endmodule

// File: tb/test_dmtlb.sv
`timescale 1ns/1ps
module test_dmtlb;

  localparam int VPN_W = 20;
  localparam int PPN_W = 18;
  localparam int SLOTS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush_all = 1'b0;
  logic req_valid = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic pt_req_ready = 1'b0;
  logic pt_rsp_valid = 1'b0;
  logic [PPN_W-1:0] pt_rsp_ppn = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_rd, rsp_wr, pt_req_valid;
  logic [PPN_W-1:0] rsp_ppn;
  logic [VPN_W-1:0] pt_req_vpn;

  always #2 clk = ~clk;

  dmtlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SLOTS(SLOTS)) i_dmtlb (
    .clk(clk), .rst(rst), .flush_all(flush_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .pt_req_valid(pt_req_valid), .pt_req_ready(pt_req_ready), .pt_req_vpn(pt_req_vpn),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_ppn(pt_rsp_ppn)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference table
  bit               m_vld [SLOTS];
  logic [VPN_W-1:0] m_tag [SLOTS];
  logic [PPN_W-1:0] m_ppn [SLOTS];

  function automatic logic [PPN_W-1:0] page_table(input logic [VPN_W-1:0] v);
    logic [31:0] t;
    t = ({12'h0, v} * 32'd40503) ^ 32'h0002_5A3C;
    return t[PPN_W-1:0];
  endfunction

  function automatic int slot_ref(input logic [VPN_W-1:0] v);
    return int'(v / (1 << (VPN_W - 4)));
  endfunction

  task automatic model_clear();
    for (int s = 0; s < SLOTS; s++) m_vld[s] = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One lookup, driven and checked at falling edges.
  task automatic lookup(input logic [VPN_W-1:0] v, input string req,
                        input bit fl_same, input bit fl_wait, input bit fl_fill,
                        input int rdy_dly, input int rsp_dly);
    int  idx;
    bit  exp_hit;
    idx = slot_ref(v);
    check(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
    if (fl_same) model_clear();
    exp_hit = m_vld[idx] && (m_tag[idx] == v);
    req_valid = 1'b1; req_vpn = v; flush_all = fl_same;
    @(negedge clk);
    req_valid = 1'b0; flush_all = 1'b0;
    check(rsp_valid == exp_hit, req, "hit/miss verdict", rsp_valid, exp_hit);
    if (exp_hit) begin
      check(rsp_hit == 1'b1 && rsp_rd && rsp_wr, "R2", "hit flags",
            {rsp_hit, rsp_rd, rsp_wr}, 3'b111);
      check(rsp_ppn == m_ppn[idx], "R2", "hit ppn", rsp_ppn, m_ppn[idx]);
      check(req_ready == 1'b0, "R10", "busy during hit reply", req_ready, 0);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R10", "reply is one cycle", rsp_valid, 0);
    end else begin
      check(pt_req_valid && pt_req_vpn == v, "R3", "page-table request",
            pt_req_vpn, v);
      for (int k = 0; k < rdy_dly; k++) begin
        @(negedge clk);
        check(pt_req_valid && pt_req_vpn == v && !rsp_valid, "R3",
              "request held", pt_req_vpn, v);
      end
      pt_req_ready = 1'b1;
      @(negedge clk);
      pt_req_ready = 1'b0;
      check(pt_req_valid == 1'b0, "R3", "request dropped", pt_req_valid, 0);
      for (int k = 0; k < rsp_dly; k++) begin
        if (fl_wait && k == rsp_dly - 1) begin
          flush_all = 1'b1;
          model_clear();
        end
        @(negedge clk);
        flush_all = 1'b0;
        check(!rsp_valid && !req_ready, "R10", "idle wait for reply",
              {rsp_valid, req_ready}, 0);
      end
      pt_rsp_valid = 1'b1; pt_rsp_ppn = page_table(v);
      @(negedge clk);
      pt_rsp_valid = 1'b0;
      check(rsp_valid && !rsp_hit && rsp_rd && rsp_wr, "R4", "refill flags",
            {rsp_valid, rsp_hit, rsp_rd, rsp_wr}, 4'b1011);
      check(rsp_ppn == page_table(v), "R4", "refill ppn", rsp_ppn, page_table(v));
      if (fl_fill) begin
        flush_all = 1'b1;
        model_clear();
      end
      @(negedge clk);
      flush_all = 1'b0;
      check(!req_ready && !rsp_valid, "R5", "refill still running",
            {req_ready, rsp_valid}, 0);
      @(negedge clk);
      check(req_ready == 1'b1, "R5", "refill finished", req_ready, 1);
      m_vld[idx] = 1'b1; m_tag[idx] = v; m_ppn[idx] = page_table(v);
    end
  endtask

  function automatic logic [VPN_W-1:0] mk(input int top, input int low);
    return {4'(top), 16'(low)};
  endfunction

  initial begin
    logic [15:0] lf;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !pt_req_valid, "R9", "reset outputs",
          {req_ready, rsp_valid, pt_req_valid}, 3'b100);

    // R1: one page per slot, all distinct slots -> all misses then all hits
    for (int i = 0; i < SLOTS; i++) lookup(mk(i, i * 37 + 5), "R1", 0, 0, 0, i % 3, i % 4);
    for (int i = 0; i < SLOTS; i++) lookup(mk(i, i * 37 + 5), "R1", 0, 0, 0, 0, 0);
    // R2: same again, low bits must match fully
    for (int i = 0; i < SLOTS; i++) lookup(mk(i, i * 37 + 5), "R2", 0, 0, 0, 0, 0);

    // R6: conflicting pages in the same slot evict each other
    for (int i = 0; i < SLOTS; i += 3) begin
      lookup(mk(i, ~(i * 37 + 5)), "R6", 0, 0, 0, 1, 1);
      lookup(mk(i, i * 37 + 5), "R6", 0, 0, 0, 0, 2);
      lookup(mk(i, ~(i * 37 + 5)), "R6", 0, 0, 0, 0, 0);
    end

    // R7: flush in the same cycle as an accepted request
    lookup(mk(1, 1 * 37 + 5), "R7", 1, 0, 0, 0, 1);
    lookup(mk(2, 2 * 37 + 5), "R7", 0, 0, 0, 0, 1);
    lookup(mk(1, 1 * 37 + 5), "R7", 0, 0, 0, 0, 0);

    // R8: flush during the reply wait and during the tag write
    for (int i = 3; i < 8; i++) lookup(mk(i, 100 + i), "R8", 0, 0, 0, 0, 0);
    lookup(mk(9, 99), "R8", 0, 1, 0, 0, 2);
    lookup(mk(9, 99), "R8", 0, 0, 0, 0, 0);
    lookup(mk(4, 104), "R8", 0, 0, 0, 0, 0);
    lookup(mk(10, 77), "R8", 0, 0, 1, 1, 1);
    lookup(mk(10, 77), "R8", 0, 0, 0, 0, 0);
    lookup(mk(9, 99), "R8", 0, 0, 0, 0, 0);

    // R9: reset mid-run empties the table
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    check(req_ready && !rsp_valid && !pt_req_valid, "R9", "reset outputs again",
          {req_ready, rsp_valid, pt_req_valid}, 3'b100);
    lookup(mk(10, 77), "R9", 0, 0, 0, 0, 0);

    // mixed sweep: 16 slots x 2 low patterns, occasional flush
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lookup(mk(int'(lf[3:0]), lf[4] ? 16'h1234 : 16'h00F0), "R2",
             (lf[9:5] == 5'd0), 0, 0, int'(lf[11:10]), int'(lf[13:12]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule